// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer with Flash and Pause Timing

This block turns a keyed digit into a train of loop-break pulses on a dial-pulse drive output, holds the line muted while the train runs, and signals completion with a one-cycle done flag. It also times flash breaks and pause intervals on request. All intervals are counted in whole milliseconds. A millisecond tick is made inside the block by dividing the system clock.

A controller presents one command at a time: a digit with its strobe, a flash request with a length code, or a pause request with a length code. The pulse rate and the make/break ratio are selected by level inputs. They are captured when a digit is accepted, so one digit's train always keeps a single timing. While a command runs, the block ignores new requests. The controller waits for the done flag before it sends the next command.

Top module: `loop_pulse_dialer`

## Requirements
- R1: A digit value of 1 to 9 produces that many break pulses, and a value of 0 produces 10. A digit value of 10 to 15 is ignored: no pulse, no mute, no done.
- R2: With rate_fast=0 (10 pulses per second), each pulse is a 60 ms break followed by a 40 ms make when ratio_third=0, and a 67 ms break followed by a 33 ms make when ratio_third=1.
- R3: With rate_fast=1 (20 pulses per second), each pulse is a 30 ms break followed by a 20 ms make when ratio_third=0, and a 33 ms break followed by a 17 ms make when ratio_third=1.
- R4: The last pulse's make is followed by an 800 ms inter-digit make. Then done is high for exactly one cycle. mute is high from the cycle after acceptance until done.
- R5: A flash request breaks the line (line_break=1, mute=1) for 600, 100, 300 or 73 ms for flash_sel 0, 1, 2 and 3. Done follows.
- R6: A pause request holds line_break=0 and mute=0 for 1000 ms (pause_sel 0 or 3), 3600 ms (pause_sel 1) or 2000 ms (pause_sel 2). Done follows.
- R7: Any request that arrives while a digit, flash or pause is running is ignored and leaves the running timing unchanged.
- R8: When several requests are strobed in the same idle cycle, a flash wins over a digit, and a valid digit wins over a pause.
- R9: During and after reset, and whenever no command runs, line_break, mute and done are 0.
- R10: Each millisecond is exactly CLK_PER_MS clock cycles. Every interval starts at the clock edge that accepts the command or ends the previous phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dig_valid | input | 1 | Digit strobe, one cycle |
| dig_val | input | 4 | Digit value (0 means ten pulses) |
| rate_fast | input | 1 | 0: 10 pulses/s, 1: 20 pulses/s |
| ratio_third | input | 1 | 0: 40:60 make:break, 1: 33.3:66.7 |
| flash_valid | input | 1 | Flash request strobe |
| flash_sel | input | 2 | Flash length code |
| pause_valid | input | 1 | Pause request strobe |
| pause_sel | input | 2 | Pause length code |
| line_break | output | 1 | Dial-pulse drive, 1 = loop broken |
| mute | output | 1 | Speech mute during pulsing and flash |
| done | output | 1 | One-cycle completion flag |

## Verification
The assertions assume that the inputs change synchronously to the clock, that every strobe lasts one cycle, and that CLK_PER_MS is at least 2. With those assumptions, the millisecond counter can only move on a tick or a reload. The stimulus drives every input on the falling edge, holds each strobe for exactly one cycle, and keeps the rate and ratio selects steady while a train runs. It sends a new command only after the expected done cycle has passed. The exceptions are the deliberate busy-time and same-cycle requests.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

  localparam int MS_W   = 12;
  localparam int PCNT_W = 4;
  localparam int IDG_MS = 800;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_MAKE,
    ST_IDG,
    ST_FLASH,
    ST_PAUSE
  } dial_st_t;

  function automatic logic [MS_W-1:0] brk_ms(input logic fast, input logic third);
    case ({fast, third})
      2'b00:   brk_ms = MS_W'(60);
      2'b01:   brk_ms = MS_W'(67);
      2'b10:   brk_ms = MS_W'(30);
      default: brk_ms = MS_W'(33);
    endcase
  endfunction

  function automatic logic [MS_W-1:0] make_ms(input logic fast, input logic third);
    case ({fast, third})
      2'b00:   make_ms = MS_W'(40);
      2'b01:   make_ms = MS_W'(33);
      2'b10:   make_ms = MS_W'(20);
      default: make_ms = MS_W'(17);
    endcase
  endfunction

  function automatic logic [MS_W-1:0] flash_ms(input logic [1:0] sel);
    case (sel)
      2'd0:    flash_ms = MS_W'(600);
      2'd1:    flash_ms = MS_W'(100);
      2'd2:    flash_ms = MS_W'(300);
      default: flash_ms = MS_W'(73);
    endcase
  endfunction

  function automatic logic [MS_W-1:0] pause_ms(input logic [1:0] sel);
    case (sel)
      2'd1:    pause_ms = MS_W'(3600);
      2'd2:    pause_ms = MS_W'(2000);
      default: pause_ms = MS_W'(1000);
    endcase
  endfunction

endpackage

// File: rtl/lpd_ms_tick.sv
module lpd_ms_tick #(
  parameter int CLK_PER_MS = 3580
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DIV_W = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;

  logic [DIV_W-1:0] div_q, div_d;

  assign tick = (div_q == DIV_W'(CLK_PER_MS - 1));

  always_comb begin
    if (clr || tick) div_d = '0;
    else             div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/lpd_ms_timer.sv
module lpd_ms_timer
  import lpd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] len,
  input  logic            tick,
  output logic            expire,
  output logic [MS_W-1:0] ms_left
);
  logic [MS_W-1:0] cnt_d;

  assign expire = tick && (ms_left == MS_W'(1));

  always_comb begin
    cnt_d = ms_left;
    if (load)                             cnt_d = len;
    else if (tick && (ms_left != '0))     cnt_d = ms_left - MS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ms_left <= '0;
    else        ms_left <= cnt_d;
  end
endmodule

// File: rtl/lpd_dial_fsm.sv
module lpd_dial_fsm
  import lpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dig_valid,
  input  logic [3:0]        dig_val,
  input  logic              rate_fast,
  input  logic              ratio_third,
  input  logic              flash_valid,
  input  logic [1:0]        flash_sel,
  input  logic              pause_valid,
  input  logic [1:0]        pause_sel,
  input  logic              expire,
  output logic              tmr_load,
  output logic [MS_W-1:0]   tmr_len,
  output logic              line_break,
  output logic              mute,
  output logic              done,
  output logic [PCNT_W-1:0] pulses_left
);
  dial_st_t          st_q, st_d;
  logic [PCNT_W-1:0] pl_d;
  logic              fast_q, fast_d, third_q, third_d, done_d;
  logic              dig_ok;
  logic [PCNT_W-1:0] dig_n;

  assign dig_ok = (dig_val <= 4'd9);
  assign dig_n  = (dig_val == 4'd0) ? PCNT_W'(10) : PCNT_W'(dig_val);

  always_comb begin
    st_d     = st_q;
    pl_d     = pulses_left;
    fast_d   = fast_q;
    third_d  = third_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    case (st_q)
      ST_IDLE: begin
        if (flash_valid) begin
          st_d     = ST_FLASH;
          tmr_load = 1'b1;
          tmr_len  = flash_ms(flash_sel);
        end else if (dig_valid && dig_ok) begin
          st_d     = ST_BRK;
          pl_d     = dig_n;
          fast_d   = rate_fast;
          third_d  = ratio_third;
          tmr_load = 1'b1;
          tmr_len  = brk_ms(rate_fast, ratio_third);
        end else if (pause_valid) begin
          st_d     = ST_PAUSE;
          tmr_load = 1'b1;
          tmr_len  = pause_ms(pause_sel);
        end
      end
      ST_BRK: begin
        if (expire) begin
          st_d     = ST_MAKE;
          tmr_load = 1'b1;
          tmr_len  = make_ms(fast_q, third_q);
        end
      end
      ST_MAKE: begin
        if (expire) begin
          tmr_load = 1'b1;
          if (pulses_left == PCNT_W'(1)) begin
            st_d    = ST_IDG;
            pl_d    = '0;
            tmr_len = MS_W'(IDG_MS);
          end else begin
            st_d    = ST_BRK;
            pl_d    = pulses_left - PCNT_W'(1);
            tmr_len = brk_ms(fast_q, third_q);
          end
        end
      end
      ST_IDG, ST_FLASH, ST_PAUSE: begin
        if (expire) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      pulses_left <= '0;
      fast_q      <= 1'b0;
      third_q     <= 1'b0;
      done        <= 1'b0;
    end else begin
      st_q        <= st_d;
      pulses_left <= pl_d;
      fast_q      <= fast_d;
      third_q     <= third_d;
      done        <= done_d;
    end
  end

  assign line_break = (st_q == ST_BRK) || (st_q == ST_FLASH);
  assign mute       = (st_q != ST_IDLE) && (st_q != ST_PAUSE);
endmodule

// File: rtl/loop_pulse_dialer.sv
module loop_pulse_dialer
  import lpd_pkg::*;
#(
  parameter int CLK_PER_MS = 3580
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dig_valid,
  input  logic [3:0] dig_val,
  input  logic       rate_fast,
  input  logic       ratio_third,
  input  logic       flash_valid,
  input  logic [1:0] flash_sel,
  input  logic       pause_valid,
  input  logic [1:0] pause_sel,
  output logic       line_break,
  output logic       mute,
  output logic       done
);
  logic              tick, expire, tmr_load;
  logic [MS_W-1:0]   tmr_len, ms_left;
  logic [PCNT_W-1:0] pulses_left;

  lpd_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_load),
    .tick  (tick)
  );

  lpd_ms_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (tmr_len),
    .tick    (tick),
    .expire  (expire),
    .ms_left (ms_left)
  );

  lpd_dial_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dig_valid   (dig_valid),
    .dig_val     (dig_val),
    .rate_fast   (rate_fast),
    .ratio_third (ratio_third),
    .flash_valid (flash_valid),
    .flash_sel   (flash_sel),
    .pause_valid (pause_valid),
    .pause_sel   (pause_sel),
    .expire      (expire),
    .tmr_load    (tmr_load),
    .tmr_len     (tmr_len),
    .line_break  (line_break),
    .mute        (mute),
    .done        (done),
    .pulses_left (pulses_left)
  );
endmodule

// File: rtl/lpd_checker.sv
module lpd_checker
  import lpd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              line_break,
  input logic              mute,
  input logic              done,
  input logic              tick,
  input logic              tmr_load,
  input logic [MS_W-1:0]   ms_left,
  input logic [PCNT_W-1:0] pulses_left
);
  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!line_break && !mute));

  a_r5_break_muted: assert property (@(posedge clk) disable iff (!rst_n)
    line_break |-> mute);

  a_r1_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_left <= PCNT_W'(10));

  a_r10_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_load && !tick) |=> $stable(ms_left));
endmodule

bind loop_pulse_dialer lpd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_break  (line_break),
  .mute        (mute),
  .done        (done),
  .tick        (tick),
  .tmr_load    (tmr_load),
  .ms_left     (ms_left),
  .pulses_left (pulses_left)
);

// File: tb/loop_pulse_dialer_bench.sv
module loop_pulse_dialer_bench;
  localparam int CPM = 4;

  logic clk, rst_n;
  logic dig_valid, rate_fast, ratio_third, flash_valid, pause_valid;
  logic [3:0] dig_val;
  logic [1:0] flash_sel, pause_sel;
  logic line_break, mute, done;

  typedef struct {
    bit    lb;
    bit    mu;
    bit    dn;
    int    len;
    string tag;
  } seg_t;

  seg_t  q[$];
  int    vectors = 0;
  int    miscompares = 0;
  string idle_tag = "R9";
  bit    finished = 0;

  loop_pulse_dialer #(.CLK_PER_MS(CPM)) u_loop_pulse_dialer (
    .clk(clk), .rst_n(rst_n), .dig_valid(dig_valid), .dig_val(dig_val),
    .rate_fast(rate_fast), .ratio_third(ratio_third),
    .flash_valid(flash_valid), .flash_sel(flash_sel),
    .pause_valid(pause_valid), .pause_sel(pause_sel),
    .line_break(line_break), .mute(mute), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int brk_of(bit f, bit t);
    if (!f) return t ? 67 : 60;
    return t ? 33 : 30;
  endfunction
  function automatic int mk_of(bit f, bit t);
    if (!f) return t ? 33 : 40;
    return t ? 17 : 20;
  endfunction

  task automatic push(bit lb, bit mu, bit dn, int ms_or_cyc, bit in_ms, string tag);
    seg_t s;
    s.lb = lb; s.mu = mu; s.dn = dn;
    s.len = in_ms ? ms_or_cyc * CPM : ms_or_cyc;
    s.tag = tag;
    q.push_back(s);
  endtask

  task automatic strobe_clear();
    @(negedge clk);
    dig_valid = 0; flash_valid = 0; pause_valid = 0;
  endtask

  task automatic expect_digit(int d, bit f, bit t, string tag);
    int n = (d == 0) ? 10 : d;
    for (int i = 0; i < n; i++) begin
      push(1, 1, 0, brk_of(f, t), 1, tag);
      push(0, 1, 0, mk_of(f, t), 1, tag);
    end
    push(0, 1, 0, 800, 1, "R4");
    push(0, 0, 1, 1, 0, "R4");
  endtask

  task automatic send_digit(int d, bit f, bit t, string tag);
    @(negedge clk);
    dig_valid = 1; dig_val = 4'(d); rate_fast = f; ratio_third = t;
    expect_digit(d, f, t, tag);
    strobe_clear();
  endtask

  task automatic send_flash(int s);
    int ms;
    case (s) 0: ms = 600; 1: ms = 100; 2: ms = 300; default: ms = 73; endcase
    @(negedge clk);
    flash_valid = 1; flash_sel = 2'(s);
    push(1, 1, 0, ms, 1, "R5");
    push(0, 0, 1, 1, 0, "R5");
    strobe_clear();
  endtask

  task automatic send_pause(int s);
    int ms;
    case (s) 1: ms = 3600; 2: ms = 2000; default: ms = 1000; endcase
    @(negedge clk);
    pause_valid = 1; pause_sel = 2'(s);
    push(0, 0, 0, ms, 1, "R6");
    push(0, 0, 1, 1, 0, "R6");
    strobe_clear();
  endtask

  task automatic settle(int cyc, string tag);
    wait (q.size() == 0);
    idle_tag = tag;
    repeat (cyc) @(negedge clk);
    vectors++;
    idle_tag = "R9";
  endtask

  // monitor: compare outputs against queue head, or against idle when empty
  initial begin
    int  pos = 0;
    bit  bad = 0;
    bit  idle_bad = 0;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !finished) begin
        if (q.size() > 0) begin
          idle_bad = 0;
          if (!bad && (line_break !== q[0].lb || mute !== q[0].mu || done !== q[0].dn)) begin
            bad = 1;
            miscompares++;
            $display("FAIL %s: seg cycle %0d got lb=%b mute=%b done=%b exp lb=%b mute=%b done=%b",
                     q[0].tag, pos, line_break, mute, done, q[0].lb, q[0].mu, q[0].dn);
          end
          pos++;
          if (pos >= q[0].len) begin
            vectors++;
            pos = 0; bad = 0;
            void'(q.pop_front());
          end
        end else if (!idle_bad && (line_break !== 0 || mute !== 0 || done !== 0)) begin
          idle_bad = 1;
          miscompares++;
          $display("FAIL %s: idle got lb=%b mute=%b done=%b exp 0 0 0",
                   idle_tag, line_break, mute, done);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dig_valid = 0; dig_val = 0; rate_fast = 0; ratio_third = 0;
    flash_valid = 0; flash_sel = 0; pause_valid = 0; pause_sel = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (line_break !== 0 || mute !== 0 || done !== 0) begin
      miscompares++;
      $display("FAIL R9: reset got lb=%b mute=%b done=%b exp 0 0 0", line_break, mute, done);
    end
    rst_n = 1;
    settle(10, "R9");

    // R2: 10 pps, both ratios; R1 count
    send_digit(3, 0, 0, "R2");
    settle(5, "R9");
    send_digit(7, 0, 1, "R2");
    settle(5, "R9");
    // R3: 20 pps, both ratios; R1 zero gives ten
    send_digit(0, 1, 1, "R3");
    settle(5, "R9");
    send_digit(1, 1, 0, "R3");
    settle(5, "R9");
    // R1: out-of-range digits ignored
    @(negedge clk); dig_valid = 1; dig_val = 4'd12; strobe_clear();
    settle(40, "R1");
    @(negedge clk); dig_valid = 1; dig_val = 4'd10; strobe_clear();
    settle(40, "R1");
    // R5: all flash lengths
    for (int s = 0; s < 4; s++) begin
      send_flash(s);
      settle(5, "R9");
    end
    // R6: all pause codes
    for (int s = 0; s < 4; s++) begin
      send_pause(s);
      settle(5, "R9");
    end
    // R7: requests during a running digit and a running pause are ignored
    send_digit(2, 0, 0, "R7");
    repeat (30) @(negedge clk);
    flash_valid = 1; flash_sel = 0; pause_valid = 1; dig_valid = 1; dig_val = 4'd5;
    strobe_clear();
    repeat (400 * CPM) @(negedge clk);
    dig_valid = 1; dig_val = 4'd9; strobe_clear();
    settle(5, "R7");
    send_pause(2);
    repeat (100) @(negedge clk);
    flash_valid = 1; flash_sel = 1; strobe_clear();
    settle(5, "R7");
    // R8: flash beats digit beats pause
    @(negedge clk);
    flash_valid = 1; flash_sel = 3; dig_valid = 1; dig_val = 4'd4; pause_valid = 1;
    push(1, 1, 0, 73, 1, "R8");
    push(0, 0, 1, 1, 0, "R8");
    strobe_clear();
    settle(5, "R8");
    @(negedge clk);
    dig_valid = 1; dig_val = 4'd1; rate_fast = 1; ratio_third = 0;
    pause_valid = 1; pause_sel = 1;
    expect_digit(1, 1, 0, "R8");
    strobe_clear();
    settle(5, "R8");
    // R10: timing exactness is covered by every segment length above
    settle(5, "R10");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule